// File: doc/BRIEF.md
# Protection Page-Split Detector

This block sits beside the translation cache of a processor core that enforces physical memory protection through an ordered list of address ranges. When the cache is about to record a translation, it needs to know whether one set of permissions holds for every byte of the 4 KiB page around the looked-up address. If one set holds for the whole page, the whole page can be cached. If not, the cache must hold only a single byte, so that every later access to that page is checked again.

The block takes each entry's inclusive start and end address, which are already decoded, together with a mask of the entries whose mode is not off, a global protection enable and the lookup address. It captures these inputs in registers on each clock. It then scans the entries from index 0 upward. Entries that neither cover the page nor reach into it are passed over. The first entry that does either one decides the result: an entry that covers the whole page gives a whole-page grant, and an entry that covers only part of it gives a single-byte grant. The verdict comes out as a one-bit flag and as the matching size value.

Top module: `pmpps_page_split`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `whole_page` is 1 and `grant_size` is 4096.
- R2: When `pmp_en` is 0, the result is whole page, whatever the entries hold.
- R3: When `entry_act` is all zeros, the result is whole page.
- R4: An entry whose `entry_act` bit is 0 is skipped, even if its range reaches into or covers the page.
- R5: If the lowest-indexed active entry that covers or reaches into the page has start ≤ page start and end ≥ page end, the result is whole page, even if a higher-indexed entry covers only part of the page.
- R6: If that lowest-indexed entry covers only part of the page, the result is single byte, even if a higher-indexed entry covers the whole page.
- R7: An entry reaches into the page when its start lies within [page start, page end] or its end lies within it. Either case on its own is enough.
- R8: Active entries that lie entirely outside the page do not stop the scan. If no active entry covers or reaches into the page, the result is whole page.
- R9: The page start is the lookup address with its low 12 bits cleared. The page end is the page start plus 4095. All addresses within one page give the same result.
- R10: The outputs depend only on inputs captured at the most recent rising clock edge. A change to an input has no effect on the outputs until the next edge.
- R11: `grant_size` is 4096 when `whole_page` is 1 and 1 when `whole_page` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| pmp_en | input | 1 | Global protection enable |
| entry_act | input | N_ENT | One bit per entry, set when the entry's mode is not off |
| entry_lo | input | N_ENT*ADDR_W | Inclusive start address per entry, entry i in bits [i*ADDR_W +: ADDR_W] |
| entry_hi | input | N_ENT*ADDR_W | Inclusive end address per entry, same packing |
| lookup_addr | input | ADDR_W | Address whose page is being judged |
| whole_page | output | 1 | 1 = the whole page may be cached, 0 = a single byte only |
| grant_size | output | PAGE_BITS+1 | Cacheable size in bytes: 4096 or 1 |

## Verification
A fault in the captured inputs or in the priority chain would show as a wrong verdict on the outputs one cycle after the stimulus. There is no further state that could hide it or carry it over to later lookups. The most telling faults are a low entry failing to block a higher one, an inactive entry still taking part, and a page boundary that is off by one. Directed cases target each of these. A sweep over boundary-heavy ranges compares every cycle against a reference scan.

// File: rtl/pmpps_pkg.sv
package pmpps_pkg;
  // verdict of the page scan
  typedef enum logic {
    SPAN_BYTE  = 1'b0,
    SPAN_WHOLE = 1'b1
  } span_e;
endpackage

// File: rtl/pmpps_entry_cmp.sv
// Classifies one entry against the page window.
module pmpps_entry_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic              act,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] pg_lo,
  input  logic [ADDR_W-1:0] pg_hi,
  output logic              covers,
  output logic              touches
);
  logic lo_in_page;
  logic hi_in_page;

  always_comb begin
    lo_in_page = (lo >= pg_lo) && (lo <= pg_hi);
    hi_in_page = (hi >= pg_lo) && (hi <= pg_hi);
    covers     = act && (lo <= pg_lo) && (hi >= pg_hi);
    touches    = act && (lo_in_page || hi_in_page);
  end
endmodule

// File: rtl/pmpps_first_hit.sv
// Lowest-index-wins selection among entries that hit the page.
module pmpps_first_hit #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0] hit,
  input  logic [N_ENT-1:0] full,
  output logic             any_hit,
  output logic             first_full
);
  logic [N_ENT:0]   seen;
  logic [N_ENT-1:0] pick;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_ENT; i++) begin : g_chain
    assign seen[i+1] = seen[i] | hit[i];
    assign pick[i]   = hit[i] & ~seen[i] & full[i];
  end

  assign any_hit    = seen[N_ENT];
  assign first_full = |pick;
endmodule

// File: rtl/pmpps_page_split.sv
module pmpps_page_split
  import pmpps_pkg::*;
#(
  parameter int N_ENT     = 4,
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pmp_en,
  input  logic [N_ENT-1:0]         entry_act,
  input  logic [N_ENT*ADDR_W-1:0]  entry_lo,
  input  logic [N_ENT*ADDR_W-1:0]  entry_hi,
  input  logic [ADDR_W-1:0]        lookup_addr,
  output logic                     whole_page,
  output logic [PAGE_BITS:0]       grant_size
);
  localparam int SIZE_W = PAGE_BITS + 1;
  localparam int HI_W   = ADDR_W - PAGE_BITS;
  localparam logic [SIZE_W-1:0] SZ_PAGE = SIZE_W'(1) << PAGE_BITS;
  localparam logic [SIZE_W-1:0] SZ_BYTE = SIZE_W'(1);

  // captured inputs
  logic                    en_q,   en_d;
  logic [N_ENT-1:0]        act_q,  act_d;
  logic [N_ENT*ADDR_W-1:0] lo_q,   lo_d;
  logic [N_ENT*ADDR_W-1:0] hi_q,   hi_d;
  logic [ADDR_W-1:0]       addr_q, addr_d;
  logic                    cap_en;

  // capture every cycle; enable kept explicit
  always_comb begin
    cap_en = 1'b1;
    en_d   = pmp_en;
    act_d  = entry_act;
    lo_d   = entry_lo;
    hi_d   = entry_hi;
    addr_d = lookup_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      act_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      addr_q <= '0;
    end else if (cap_en) begin
      en_q   <= en_d;
      act_q  <= act_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      addr_q <= addr_d;
    end
  end

  // page window
  logic [ADDR_W-1:0] pg_lo;
  logic [ADDR_W-1:0] pg_hi;
  logic [HI_W-1:0]   pg_num;

  always_comb begin
    pg_num = addr_q[ADDR_W-1:PAGE_BITS];
    pg_lo  = {pg_num, {PAGE_BITS{1'b0}}};
    pg_hi  = {pg_num, {PAGE_BITS{1'b1}}};
  end

  // per-entry classification
  logic [N_ENT-1:0] cov;
  logic [N_ENT-1:0] tch;
  logic [N_ENT-1:0] hit;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    pmpps_entry_cmp #(.ADDR_W(ADDR_W)) i_cmp (
      .act     (act_q[i]),
      .lo      (lo_q[i*ADDR_W +: ADDR_W]),
      .hi      (hi_q[i*ADDR_W +: ADDR_W]),
      .pg_lo   (pg_lo),
      .pg_hi   (pg_hi),
      .covers  (cov[i]),
      .touches (tch[i])
    );
    assign hit[i] = cov[i] | tch[i];
  end

  logic any_hit;
  logic first_full;

  pmpps_first_hit #(.N_ENT(N_ENT)) i_pick (
    .hit        (hit),
    .full       (cov),
    .any_hit    (any_hit),
    .first_full (first_full)
  );

  span_e span;

  always_comb begin
    if (!en_q || !any_hit || first_full) span = SPAN_WHOLE;
    else                                 span = SPAN_BYTE;
    whole_page = (span == SPAN_WHOLE);
    grant_size = whole_page ? SZ_PAGE : SZ_BYTE;
  end
endmodule

// File: rtl/pmpps_checker.sv
module pmpps_checker #(
  parameter int N_ENT     = 4,
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pmp_en,
  input logic [N_ENT-1:0]        entry_act,
  input logic [N_ENT*ADDR_W-1:0] entry_lo,
  input logic [N_ENT*ADDR_W-1:0] entry_hi,
  input logic [ADDR_W-1:0]       lookup_addr,
  input logic                    whole_page,
  input logic [PAGE_BITS:0]      grant_size
);
  logic              primed;
  logic [ADDR_W-1:0] c_plo;
  logic [ADDR_W-1:0] c_phi;
  logic [ADDR_W-1:0] e0_lo;
  logic [ADDR_W-1:0] e0_hi;
  logic              e0_full;
  logic              e0_part;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  always_comb begin
    c_plo   = {lookup_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    c_phi   = {lookup_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b1}}};
    e0_lo   = entry_lo[ADDR_W-1:0];
    e0_hi   = entry_hi[ADDR_W-1:0];
    e0_full = pmp_en && entry_act[0] && e0_lo <= c_plo && e0_hi >= c_phi;
    e0_part = pmp_en && entry_act[0] && !(e0_lo <= c_plo && e0_hi >= c_phi) &&
              ((e0_lo >= c_plo && e0_lo <= c_phi) || (e0_hi >= c_plo && e0_hi <= c_phi));
  end

  a_r2_disabled_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!pmp_en)) |-> whole_page);

  a_r3_none_active_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(entry_act == '0)) |-> whole_page);

  a_r5_lowest_full_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(e0_full)) |-> whole_page);

  a_r6_lowest_part_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(e0_part)) |-> !whole_page);

  a_r11_size_code: assert property (@(posedge clk) disable iff (!rst_n)
    whole_page ? (grant_size == (PAGE_BITS+1)'(1) << PAGE_BITS)
               : (grant_size == (PAGE_BITS+1)'(1)));
endmodule

bind pmpps_page_split pmpps_checker #(
  .N_ENT(N_ENT), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
) i_pmpps_checker (
  .clk(clk), .rst_n(rst_n), .pmp_en(pmp_en), .entry_act(entry_act),
  .entry_lo(entry_lo), .entry_hi(entry_hi), .lookup_addr(lookup_addr),
  .whole_page(whole_page), .grant_size(grant_size)
);

// File: tb/test_pmpps_page_split.sv
module test_pmpps_page_split;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int PB = 12;

  logic            clk;
  logic            rst_n;
  logic            pmp_en;
  logic [N-1:0]    entry_act;
  logic [N*AW-1:0] entry_lo;
  logic [N*AW-1:0] entry_hi;
  logic [AW-1:0]   lookup_addr;
  logic            whole_page;
  logic [PB:0]     grant_size;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  pmpps_page_split #(.N_ENT(N), .ADDR_W(AW), .PAGE_BITS(PB)) i_pmpps_page_split (
    .clk(clk), .rst_n(rst_n), .pmp_en(pmp_en), .entry_act(entry_act),
    .entry_lo(entry_lo), .entry_hi(entry_hi), .lookup_addr(lookup_addr),
    .whole_page(whole_page), .grant_size(grant_size)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference scan written from the requirements
  function automatic bit ref_whole(bit en, logic [N-1:0] act, logic [N*AW-1:0] lo,
                                   logic [N*AW-1:0] hi, logic [AW-1:0] a);
    logic [AW-1:0] plo, phi, s, e;
    plo = a & ~AW'(4095);
    phi = plo + AW'(4095);
    if (!en) return 1'b1;
    for (int i = 0; i < N; i++) begin
      if (!act[i]) continue;
      s = lo[i*AW +: AW];
      e = hi[i*AW +: AW];
      if (s <= plo && e >= phi) return 1'b1;
      if ((s >= plo && s <= phi) || (e >= plo && e <= phi)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic compare(string tag, bit exp);
    logic [PB:0] exp_sz;
    exp_sz = exp ? (PB+1)'(4096) : (PB+1)'(1);
    checks++;
    if (whole_page !== exp || grant_size !== exp_sz) begin
      errors++;
      $display("FAIL %s: whole=%0b size=%0d expected whole=%0b size=%0d",
               tag, whole_page, grant_size, exp, exp_sz);
    end
  endtask

  task automatic set_ent(int i, logic [AW-1:0] s, logic [AW-1:0] e);
    entry_lo[i*AW +: AW] = s;
    entry_hi[i*AW +: AW] = e;
  endtask

  // inputs already driven at a falling edge; step one rising edge and sample
  task automatic step_check(string tag, bit exp);
    @(posedge clk);
    @(negedge clk);
    compare(tag, exp);
  endtask

  function automatic logic [AW-1:0] pick_val(logic [2:0] k);
    case (k)
      3'd0: return 16'h0000;
      3'd1: return 16'h2FFF;
      3'd2: return 16'h3000;
      3'd3: return 16'h3001;
      3'd4: return 16'h3ABC;
      3'd5: return 16'h3FFF;
      3'd6: return 16'h4000;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic adv();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pmp_en = 1'b1; entry_act = '1;
    entry_lo = '0; entry_hi = '0; lookup_addr = 16'h3000;
    set_ent(0, 16'h3100, 16'h3200);
    repeat (3) @(negedge clk);
    compare("R1 during reset", 1'b1);
    rst_n = 1'b1;
    #1 compare("R1 right after release", 1'b1);

    // R2 disabled overrides a partial entry
    @(negedge clk);
    pmp_en = 1'b0; entry_act = 4'b0001;
    step_check("R2 disabled", 1'b1);

    // R10: enable now, output must not move before the edge
    pmp_en = 1'b1;
    #1 compare("R10 held before edge", 1'b1);
    step_check("R7 partial inside page", 1'b0);

    entry_act = '0;
    step_check("R3 none active", 1'b1);

    // R4: entry0 partial but inactive, entry1 covers
    entry_act = 4'b0010; set_ent(1, 16'h2000, 16'h5000);
    step_check("R4 inactive skipped", 1'b1);

    // R5: entry0 covers, entry1 partial
    entry_act = 4'b0011; set_ent(0, 16'h3000, 16'h3FFF); set_ent(1, 16'h3010, 16'h3020);
    step_check("R5 lowest covers", 1'b1);

    // R6: entry0 partial, entry1 covers
    set_ent(0, 16'h3800, 16'h6000); set_ent(1, 16'h0000, 16'hFFFF);
    step_check("R6 lowest partial", 1'b0);

    // R7: only end inside page
    entry_act = 4'b0001; set_ent(0, 16'h1000, 16'h3000);
    step_check("R7 end inside", 1'b0);

    // R8: outside entries do not stop the scan
    entry_act = 4'b0111;
    set_ent(0, 16'h0000, 16'h2FFF); set_ent(1, 16'h4000, 16'hFFFF); set_ent(2, 16'h3FFF, 16'h3FFF);
    step_check("R8 scan passes outside", 1'b0);
    entry_act = 4'b0011;
    step_check("R8 nothing touches", 1'b1);

    // R9: page boundaries
    entry_act = 4'b0001; set_ent(0, 16'h3FFF, 16'h4100);
    lookup_addr = 16'h3000;
    step_check("R9 page low edge", 1'b0);
    lookup_addr = 16'h3FFF;
    step_check("R9 page high edge", 1'b0);
    lookup_addr = 16'h4000;
    step_check("R9 next page", 1'b0);
    lookup_addr = 16'h2FFF;
    step_check("R9 previous page", 1'b1);

    // sweep over boundary-heavy configurations
    for (int it = 0; it < 6000; it++) begin
      logic [AW-1:0] a;
      for (int i = 0; i < N; i++) begin
        adv();
        set_ent(i, pick_val(lfsr[2:0]), pick_val(lfsr[5:3]));
      end
      adv();
      entry_act = lfsr[3:0];
      pmp_en    = (lfsr[7:4] != 4'h0);
      a = {4'h3, lfsr[19:8]};
      if (lfsr[21:20] == 2'b00) a[15:12] = lfsr[25:22];
      lookup_addr = a;
      step_check("R9 R5 R6 sweep", ref_whole(pmp_en, entry_act, entry_lo, entry_hi, a));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule